// File: doc/BRIEF.md
# Erasable Word Memory Mode Decoder and Array Model

This block is a synthesizable behavioural model of a word-wide programmable read-only memory that can be programmed once per bit and erased as a whole. The operating mode is decoded from an active-low select/program-pulse line, an active-low output enable, a flag that says the programming supply is at its high level, and a flag that says the ninth address line carries a high voltage. Depending on the mode, the model drives a stored word, drives an identifier code, writes the bus word into the array, or leaves the bus undriven.

Programming can only clear bits. The stored word becomes the old word ANDed with the bus word, so a one written over a zero leaves the zero. A synchronous erase input, and the reset, return every word to all ones. Voltage levels are reduced to logic flags. The bus is modelled as a data output and a drive flag. When the drive flag is low the data output is zero, and that stands for high impedance. Depth is set by the address width parameter. An optional registered output stage delays every output by one clock.

Top module: `uvprom_model`

## Requirements
- R1: After reset, or after a cycle with `erase` high, every word reads back as all ones (16'hFFFF).
- R2: With `prog_hv`=1, `sel_n`=0, `oe_n`=1 and `id_hv`=0 (program), the word at `addr` becomes old AND `din` at the clock edge, and the bus is not driven.
- R3: With `prog_hv`=1, `sel_n`=1 and `oe_n`=0 (verify), `dout` carries the stored word at `addr` and `dout_drive` is 1.
- R4: With `prog_hv`=1, `sel_n`=1 and `oe_n`=1 (inhibit), the bus is not driven and no word changes.
- R5: With `prog_hv`=0, `id_hv`=0, `sel_n`=0 and `oe_n`=0 (read), `dout` carries the stored word at `addr` and `dout_drive` is 1.
- R6: With `prog_hv`=0, if `sel_n`=1 (standby) or `sel_n`=0 with `oe_n`=1 (output disabled), `dout_drive`=0, `dout`=0 and no word changes.
- R7: With `id_hv`=1, `prog_hv`=0, `sel_n`=0, `oe_n`=0 and every address bit above bit 0 low (identify), the output is 16'h0001 when `addr[0]`=0 and 16'h0019 when `addr[0]`=1.
- R8: Both identifier codes have odd parity over bits 7:0, bit 7 is the parity bit, and bits 15:8 are zero.
- R9: The combinations `prog_hv`=1 with `sel_n`=0 and `oe_n`=0, `prog_hv`=1 with `id_hv`=1, and identify with any address bit above bit 0 set are illegal. In these cases `illegal_mode`=1, the bus is not driven, and no word changes.
- R10: When `erase` is high in a program cycle, the erase wins and the addressed word ends up all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; erases the array |
| erase | input | 1 | Synchronous whole-array erase to all ones |
| sel_n | input | 1 | Active-low select and program pulse |
| oe_n | input | 1 | Active-low output enable |
| prog_hv | input | 1 | Programming supply at high level |
| id_hv | input | 1 | High voltage on address line 9 |
| addr | input | AW (4) | Word address |
| din | input | DW (16) | Word to program |
| dout | output | DW (16) | Bus data, zero when undriven |
| dout_drive | output | 1 | 1 when the bus is driven |
| illegal_mode | output | 1 | Unlisted pin combination present |

## Verification
With the default unregistered output, `dout`, `dout_drive` and `illegal_mode` follow the pins and the array in the same cycle. The bench changes inputs on the falling edge and samples one nanosecond later. A program or erase takes effect at the next rising edge. The bench therefore checks the result only after that edge, by switching to verify or read mode and sampling after the following falling edge. Tests for "no change" after inhibit, standby or illegal cycles read the word back in the same way, one edge later.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_OUTDIS,
        M_READ,
        M_PROG,
        M_VERIFY,
        M_INHIBIT,
        M_IDENT,
        M_ILLEGAL
    } prom_mode_e;

    localparam logic [6:0] MFR_ID7 = 7'h01;
    localparam logic [6:0] DEV_ID7 = 7'h19;

    // Bit 7 is chosen so that the byte holds an odd number of ones.
    function automatic logic [7:0] odd_parity_code(input logic [6:0] v);
        return {~^v, v};
    endfunction

    function automatic prom_mode_e decode_mode(
        input logic sel_n,
        input logic oe_n,
        input logic prog_hv,
        input logic id_hv,
        input logic upper_zero
    );
        prom_mode_e m;
        if (prog_hv) begin
            if (id_hv) m = M_ILLEGAL;
            else begin
                case ({sel_n, oe_n})
                    2'b00:   m = M_ILLEGAL;
                    2'b01:   m = M_PROG;
                    2'b10:   m = M_VERIFY;
                    default: m = M_INHIBIT;
                endcase
            end
        end else if (sel_n) m = M_STANDBY;
        else if (oe_n)      m = M_OUTDIS;
        else if (id_hv)     m = upper_zero ? M_IDENT : M_ILLEGAL;
        else                m = M_READ;
        return m;
    endfunction

endpackage

// File: rtl/uvprom_mode_dec.sv
module uvprom_mode_dec
    import uvprom_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          sel_n,
    input  logic          oe_n,
    input  logic          prog_hv,
    input  logic          id_hv,
    input  logic [AW-1:0] addr,
    output prom_mode_e    mode
);
    logic upper_zero;

    always_comb begin
        upper_zero = (addr[AW-1:1] == '0);
        mode       = decode_mode(sel_n, oe_n, prog_hv, id_hv, upper_zero);
    end
endmodule

// File: rtl/uvprom_array.sv
module uvprom_array #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          erase,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst || erase) begin
                    cells[w] <= '1;
                end else if (wr_en && (addr == AW'(w))) begin
                    cells[w] <= cells[w] & wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = cells[addr];
endmodule

// File: rtl/uvprom_outsel.sv
module uvprom_outsel
    import uvprom_pkg::*;
#(
    parameter int DW      = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  prom_mode_e    mode,
    input  logic          addr0,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] comb_data,
    output logic          comb_drive,
    output logic          comb_illegal,
    output logic [DW-1:0] dout,
    output logic          dout_drive,
    output logic          illegal_mode
);
    always_comb begin
        comb_data    = '0;
        comb_drive   = 1'b0;
        comb_illegal = (mode == M_ILLEGAL);
        case (mode)
            M_READ, M_VERIFY: begin
                comb_data  = rd_data;
                comb_drive = 1'b1;
            end
            M_IDENT: begin
                comb_data  = DW'(odd_parity_code(addr0 ? DEV_ID7 : MFR_ID7));
                comb_drive = 1'b1;
            end
            default: ;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    dout         <= '0;
                    dout_drive   <= 1'b0;
                    illegal_mode <= 1'b0;
                end else begin
                    dout         <= comb_data;
                    dout_drive   <= comb_drive;
                    illegal_mode <= comb_illegal;
                end
            end
        end else begin : g_comb
            assign dout         = comb_data;
            assign dout_drive   = comb_drive;
            assign illegal_mode = comb_illegal;
        end
    endgenerate
endmodule

// File: rtl/uvprom_model.sv
module uvprom_model
    import uvprom_pkg::*;
#(
    parameter int AW      = 4,
    parameter int DW      = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          erase,
    input  logic          sel_n,
    input  logic          oe_n,
    input  logic          prog_hv,
    input  logic          id_hv,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_drive,
    output logic          illegal_mode
);
    prom_mode_e    mode;
    logic          wr_en;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] comb_data;
    logic          comb_drive;
    logic          comb_illegal;

    uvprom_mode_dec #(.AW(AW)) u_dec (
        .sel_n   (sel_n),
        .oe_n    (oe_n),
        .prog_hv (prog_hv),
        .id_hv   (id_hv),
        .addr    (addr),
        .mode    (mode)
    );

    assign wr_en = (mode == M_PROG);

    uvprom_array #(.AW(AW), .DW(DW)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .erase   (erase),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (din),
        .rd_data (rd_data)
    );

    uvprom_outsel #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .addr0        (addr[0]),
        .rd_data      (rd_data),
        .comb_data    (comb_data),
        .comb_drive   (comb_drive),
        .comb_illegal (comb_illegal),
        .dout         (dout),
        .dout_drive   (dout_drive),
        .illegal_mode (illegal_mode)
    );
endmodule

// File: rtl/uvprom_checker.sv
module uvprom_checker
    import uvprom_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          erase,
    input logic          sel_n,
    input logic          oe_n,
    input logic          prog_hv,
    input logic          id_hv,
    input logic [AW-1:0] addr,
    input prom_mode_e    mode,
    input logic          wr_en,
    input logic [DW-1:0] comb_data,
    input logic          comb_drive,
    input logic          comb_illegal
);
    a_r2_write_only_in_program: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (prog_hv && !sel_n && oe_n && !id_hv));

    a_r4_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
        (prog_hv && sel_n && oe_n) |-> (!comb_drive && !wr_en));

    a_r5_read_stable: assert property (@(posedge clk) disable iff (rst)
        (mode == M_READ && $past(mode == M_READ) && $stable(addr)
         && !$past(wr_en) && !$past(erase) && !$past(rst)) |-> $stable(comb_data));

    a_r6_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !prog_hv) |-> (!comb_drive && !wr_en));

    a_r8_id_parity: assert property (@(posedge clk) disable iff (rst)
        (mode == M_IDENT) |-> ((^comb_data[7:0]) && (comb_data[DW-1:8] == '0) && comb_drive));

    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        comb_illegal |-> (!comb_drive && !wr_en));
endmodule

bind uvprom_model uvprom_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .erase        (erase),
    .sel_n        (sel_n),
    .oe_n         (oe_n),
    .prog_hv      (prog_hv),
    .id_hv        (id_hv),
    .addr         (addr),
    .mode         (mode),
    .wr_en        (wr_en),
    .comb_data    (comb_data),
    .comb_drive   (comb_drive),
    .comb_illegal (comb_illegal)
);

// File: tb/uvprom_model_bench.sv
`timescale 1ns/1ps
module uvprom_model_bench;
    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          erase = 1'b0;
    logic          sel_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          prog_hv = 1'b0;
    logic          id_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_drive;
    logic          illegal_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    uvprom_model #(.AW(AW), .DW(DW)) u_uvprom_model (
        .clk          (clk),
        .rst          (rst),
        .erase        (erase),
        .sel_n        (sel_n),
        .oe_n         (oe_n),
        .prog_hv      (prog_hv),
        .id_hv        (id_hv),
        .addr         (addr),
        .din          (din),
        .dout         (dout),
        .dout_drive   (dout_drive),
        .illegal_mode (illegal_mode)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pins(input logic s, input logic o, input logic p, input logic h,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel_n = s; oe_n = o; prog_hv = p; id_hv = h; addr = a; din = d;
        #1;
    endtask

    task automatic read_word(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        pins(1'b0, 1'b0, 1'b0, 1'b0, a, '0);
        check(req, {15'd0, dout_drive, dout}, {15'd0, 1'b1, exp});
    endtask

    task automatic verify_word(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        pins(1'b1, 1'b0, 1'b1, 1'b0, a, '0);
        check(req, {15'd0, dout_drive, dout}, {15'd0, 1'b1, exp});
    endtask

    task automatic program_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        pins(1'b0, 1'b1, 1'b1, 1'b0, a, d);
        check("R2 bus quiet while programming", {dout_drive, illegal_mode}, 2'b00);
        step();
    endtask

    task automatic t_reset();
        step(); step();
        rst = 1'b0;
        #1;
        check("R6 reset standby quiet", {15'd0, dout_drive, dout}, '0);
        read_word("R1 word 0 after reset", 4'd0, 16'hFFFF);
        read_word("R1 last word after reset", 4'd15, 16'hFFFF);
    endtask

    task automatic t_program_verify();
        program_word(4'd3, 16'hF0F0);
        verify_word("R3 verify after program", 4'd3, 16'hF0F0);
        program_word(4'd3, 16'h0FFF);
        verify_word("R2 program only clears bits", 4'd3, 16'h00F0);
        read_word("R5 read programmed word", 4'd3, 16'h00F0);
        read_word("R5 read neighbour untouched", 4'd4, 16'hFFFF);
    endtask

    task automatic t_inhibit();
        pins(1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 16'h0000);
        check("R4 inhibit bus quiet", {15'd0, dout_drive, dout}, '0);
        step();
        verify_word("R4 inhibit no write", 4'd3, 16'h00F0);
    endtask

    task automatic t_disable_standby();
        pins(1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 16'h0000);
        check("R6 output disabled", {15'd0, dout_drive, dout}, '0);
        step();
        pins(1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 16'h0000);
        check("R6 standby", {15'd0, dout_drive, dout}, '0);
        step();
        read_word("R6 no write in disable/standby", 4'd3, 16'h00F0);
    endtask

    task automatic t_identify();
        pins(1'b0, 1'b0, 1'b0, 1'b1, 4'd0, '0);
        check("R7 manufacturer code", {15'd0, dout_drive, dout}, {15'd0, 1'b1, 16'h0001});
        check("R8 manufacturer parity", {31'd0, ^dout[7:0]}, 32'd1);
        pins(1'b0, 1'b0, 1'b0, 1'b1, 4'd1, '0);
        check("R7 device code", {15'd0, dout_drive, dout}, {15'd0, 1'b1, 16'h0019});
        check("R8 device parity and upper byte", {23'd0, ^dout[7:0], dout[15:8]}, {23'd0, 1'b1, 8'h00});
    endtask

    task automatic t_illegal();
        pins(1'b0, 1'b0, 1'b1, 1'b0, 4'd5, 16'h0000);
        check("R9 hv with select and enable", {dout_drive, illegal_mode}, 2'b01);
        step();
        pins(1'b0, 1'b1, 1'b1, 1'b1, 4'd5, 16'h0000);
        check("R9 both high voltages", {dout_drive, illegal_mode}, 2'b01);
        step();
        pins(1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 16'h0000);
        check("R9 identify with upper address set", {15'd0, dout_drive, dout}, '0);
        check("R9 illegal flag", {31'd0, illegal_mode}, 32'd1);
        read_word("R9 no write in illegal modes", 4'd5, 16'hFFFF);
    endtask

    task automatic t_erase();
        program_word(4'd2, 16'h1234);
        read_word("R2 program second word", 4'd2, 16'h1234);
        pins(1'b0, 1'b1, 1'b1, 1'b0, 4'd7, 16'h0000);
        erase = 1'b1;
        step();
        erase = 1'b0;
        read_word("R10 erase beats program", 4'd7, 16'hFFFF);
        read_word("R1 erase restores word 2", 4'd2, 16'hFFFF);
        read_word("R1 erase restores word 3", 4'd3, 16'hFFFF);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_program_verify();
        t_inhibit();
        t_disable_standby();
        t_identify();
        t_illegal();
        t_erase();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule